// File: doc/BRIEF.md
# Masked-Write GPIO Port Register Bank

This block holds the pin-control registers for one bank of 32 general-purpose pins, organised as four ports of eight pins each. A processor-side write/read interface reaches, for every port, a mode register (pin owned by the GPIO function), an output-enable register, an output-value register, a synchronized input register, an interrupt-enable register and an interrupt-type register. The last two are stored here and exported to a separate edge/level detector, which owns interrupt status and clearing.

Each writable register can also be reached through a second, alias address window. A write there is a masked update: the upper byte of the low half-word selects which pins change and the low byte gives their new values, so one pin can be flipped without a read-modify-write race. The bank's position in the address map (bank index times stride) and the distance to the alias window are parameters, so both common geometries (stride 0x80 with alias 0x800, stride 0x100 with alias 0x80) come from the same RTL.

Top module: `gpio_bank_regs`

## Requirements
- R1: After a synchronous active-low reset every register reads zero and no pin is driven (`pin_oe`, `pin_out`, `irq_en`, `irq_type` all zero).
- R2: A register's direct address is bank_base + group*0x10 + port*4, with bank_base = BANK_IDX*BANK_STRIDE and groups mode=0, output enable=1, output value=2, input=3, interrupt enable=5, interrupt type=6. A direct write stores data bits 7:0 (bits 23:0 for interrupt type) and reads return zero in all other bits.
- R3: A write to the alias address (direct address + ALIAS_OFS) sets bit n of the target to data bit n only where data bit 8+n is 1; all other bits, including interrupt-type bits 23:8, keep their value.
- R4: Writes to the input group, the status group (4) or the clear group (7), by either window, change no register; reads of groups 4 and 7, and of the input group through the alias window, return zero.
- R5: Pin n is driven (`pin_oe[n]`=1) only when both its mode bit and its output-enable bit are 1; `pin_out[n]` equals its output-value bit while driven and 0 while released.
- R6: A level change on `pin_in` appears in the input register (bits 7:0 of the port's word) after exactly two rising clock edges, not after one.
- R7: Address bits 3:2 of the offset select the port and bits 6:4 the group; a write to one port leaves the other ports unchanged.
- R8: Addresses outside this bank's direct and alias windows are ignored on write and read as zero.
- R9: With BANK_STRIDE=0x100, ALIAS_OFS=0x80 the same decode holds, the alias window sitting 0x80 above the bank base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Byte address of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | ADDR_W | Byte address of the read |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| pin_in | input | 32 | Pin levels from the pads |
| pin_out | output | 32 | Output value toward the pads |
| pin_oe | output | 32 | Per-pin drive enable |
| irq_en | output | 32 | Interrupt enable per pin, to the detector |
| irq_type | output | 96 | Interrupt type, 24 bits per port, to the detector |

## Verification
Every cycle the assertions check that the two-flop input path reproduces the pins exactly two cycles late, that registers hold whenever no writable group of their port is addressed, that a masked alias write disturbs no unselected bit, that at most one port sees a write strobe, and that out-of-window writes leave every exported vector stable. Reset contents, the exact merged values of alias writes, the address decode in both geometries, the zero reads of status, clear and alias-input addresses, and the pad enable combinations are shown only by the bench's directed scenarios.

// File: rtl/gpio_bank_pkg.sv
// Shared types and helpers for the GPIO port register bank.
// Assumes eight pins per port; the alias mask layout depends on it.
package gpio_bank_pkg;
    localparam int PINS_PER_PORT = 8;
    localparam int TYPE_W        = 3 * PINS_PER_PORT;
    localparam int GRP_STRIDE    = 16;
    localparam int REG_SPAN      = 8 * GRP_STRIDE;

    typedef enum logic [2:0] {
        GRP_MODE = 3'd0,
        GRP_OE   = 3'd1,
        GRP_OUT  = 3'd2,
        GRP_IN   = 3'd3,
        GRP_STAT = 3'd4,
        GRP_IEN  = 3'd5,
        GRP_TYPE = 3'd6,
        GRP_CLR  = 3'd7
    } grp_e;

    // Masked merge: bits selected by wd[15:8] take wd[7:0].
    function automatic logic [PINS_PER_PORT-1:0] masked_merge(
        input logic [PINS_PER_PORT-1:0] old_v,
        input logic [31:0]              wd
    );
        logic [PINS_PER_PORT-1:0] sel;
        sel = wd[2*PINS_PER_PORT-1:PINS_PER_PORT];
        return (old_v & ~sel) | (wd[PINS_PER_PORT-1:0] & sel);
    endfunction
endpackage

// File: rtl/gpio_addr_dec.sv
// Address decoder: maps a byte address onto (alias?, group, port).
// Assumes ALIAS_OFS >= REG_SPAN so the two windows never overlap,
// and PORTS <= 4 (port field is offset bits 3:2).
module gpio_addr_dec
    import gpio_bank_pkg::*;
#(
    parameter int ADDR_W      = 12,
    parameter int BANK_STRIDE = 'h80,
    parameter int ALIAS_OFS   = 'h800,
    parameter int BANK_IDX    = 0,
    parameter int PORTS       = 4,
    localparam int PORT_BITS  = (PORTS > 1) ? $clog2(PORTS) : 1
) (
    input  logic [ADDR_W-1:0]    addr,
    output logic                 hit,
    output logic                 is_alias,
    output grp_e                 grp,
    output logic [PORT_BITS-1:0] port
);
    localparam logic [31:0] BASE_D = 32'(BANK_IDX * BANK_STRIDE);
    localparam logic [31:0] BASE_A = 32'(BANK_IDX * BANK_STRIDE + ALIAS_OFS);

    logic [31:0] a32, off_d, off_a, off;
    logic        in_d, in_a;

    // Compute both window offsets and pick the one that hits.
    always_comb begin
        a32      = 32'(addr);
        off_d    = a32 - BASE_D;
        off_a    = a32 - BASE_A;
        in_d     = (a32 >= BASE_D) && (off_d < 32'(REG_SPAN)) && (off_d[1:0] == 2'b00);
        in_a     = (a32 >= BASE_A) && (off_a < 32'(REG_SPAN)) && (off_a[1:0] == 2'b00);
        off      = in_a ? off_a : off_d;
        grp      = grp_e'(off[6:4]);
        port     = PORT_BITS'(off[3:2]);
        is_alias = in_a;
        hit      = (in_d || in_a) && (32'(off[3:2]) < 32'(PORTS));
    end
endmodule

// File: rtl/gpio_in_sync.sv
// Two-flop synchronizer for the pin inputs of the bank.
// Assumes pins are asynchronous to clk; no glitch filtering.
module gpio_in_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    // Shift the pin levels through two stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end

    p_sync_delay_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2)) |-> (q == $past(d, 2)))
        else $error("input synchronizer latency is not two cycles");
endmodule

// File: rtl/gpio_port_regs.sv
// Register set of one eight-pin port: mode, output enable, output
// value, interrupt enable and interrupt type, plus read-word mux.
// Assumes the decoder has already qualified 'we' with the port hit.
module gpio_port_regs
    import gpio_bank_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic                     w_alias,
    input  grp_e                     w_grp,
    input  logic [31:0]              wdata,
    input  logic [PINS_PER_PORT-1:0] pins_sync,
    input  logic                     r_alias,
    input  grp_e                     r_grp,
    output logic [31:0]              rword,
    output logic [PINS_PER_PORT-1:0] pad_out,
    output logic [PINS_PER_PORT-1:0] pad_oe,
    output logic [PINS_PER_PORT-1:0] ien,
    output logic [TYPE_W-1:0]        itype
);
    localparam int P = PINS_PER_PORT;

    logic [P-1:0] mode_q, oe_q, out_q, ien_q;
    logic [TYPE_W-1:0] type_q;

    // Apply direct or masked writes to the addressed register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
            oe_q   <= '0;
            out_q  <= '0;
            ien_q  <= '0;
            type_q <= '0;
        end else if (we) begin
            unique case (w_grp)
                GRP_MODE: mode_q <= w_alias ? masked_merge(mode_q, wdata) : wdata[P-1:0];
                GRP_OE:   oe_q   <= w_alias ? masked_merge(oe_q, wdata)   : wdata[P-1:0];
                GRP_OUT:  out_q  <= w_alias ? masked_merge(out_q, wdata)  : wdata[P-1:0];
                GRP_IEN:  ien_q  <= w_alias ? masked_merge(ien_q, wdata)  : wdata[P-1:0];
                GRP_TYPE: type_q <= w_alias ? {type_q[TYPE_W-1:P], masked_merge(type_q[P-1:0], wdata)}
                                            : wdata[TYPE_W-1:0];
                default: ;
            endcase
        end
    end

    // Select the read word for the addressed group.
    always_comb begin
        rword = '0;
        unique case (r_grp)
            GRP_MODE: rword[P-1:0]      = mode_q;
            GRP_OE:   rword[P-1:0]      = oe_q;
            GRP_OUT:  rword[P-1:0]      = out_q;
            GRP_IN:   rword[P-1:0]      = r_alias ? '0 : pins_sync;
            GRP_IEN:  rword[P-1:0]      = ien_q;
            GRP_TYPE: rword[TYPE_W-1:0] = type_q;
            default:  rword             = '0;
        endcase
    end

    // Drive a pin only when it is in GPIO mode and output-enabled.
    always_comb begin
        pad_oe  = mode_q & oe_q;
        pad_out = out_q & pad_oe;
        ien     = ien_q;
        itype   = type_q;
    end

    logic writable;
    assign writable = we && (w_grp inside {GRP_MODE, GRP_OE, GRP_OUT, GRP_IEN, GRP_TYPE});

    p_hold_unwritten_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !writable |=> ($stable(mode_q) && $stable(oe_q) && $stable(out_q)
                       && $stable(ien_q) && $stable(type_q)))
        else $error("register changed without a write");

    p_alias_keeps_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (we && w_alias && w_grp == GRP_OUT) |=>
        (((out_q ^ $past(out_q)) & ~$past(wdata[2*P-1:P])) == '0))
        else $error("masked write touched an unselected bit");

    p_type_upper_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (we && w_alias) |=> (type_q[TYPE_W-1:P] == $past(type_q[TYPE_W-1:P])))
        else $error("masked write changed upper type bits");
endmodule

// File: rtl/gpio_bank_regs.sv
// Top of the GPIO port register bank: decodes direct and alias
// windows, instantiates one register set per port and the input
// synchronizer. Assumes a single-cycle write strobe and a
// combinational read path.
module gpio_bank_regs
    import gpio_bank_pkg::*;
#(
    parameter int ADDR_W      = 12,
    parameter int BANK_STRIDE = 'h80,
    parameter int ALIAS_OFS   = 'h800,
    parameter int BANK_IDX    = 0,
    parameter int PORTS       = 4,
    localparam int NPINS      = PORTS * PINS_PER_PORT,
    localparam int PORT_BITS  = (PORTS > 1) ? $clog2(PORTS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [31:0]         wr_data,
    input  logic [ADDR_W-1:0]   rd_addr,
    output logic [31:0]         rd_data,
    input  logic [NPINS-1:0]    pin_in,
    output logic [NPINS-1:0]    pin_out,
    output logic [NPINS-1:0]    pin_oe,
    output logic [NPINS-1:0]    irq_en,
    output logic [PORTS*TYPE_W-1:0] irq_type
);
    localparam int P = PINS_PER_PORT;

    logic w_hit, w_alias, r_hit, r_alias;
    grp_e w_grp, r_grp;
    logic [PORT_BITS-1:0] w_port, r_port;
    logic [NPINS-1:0] pins_s;
    logic [PORTS-1:0] port_we;
    logic [31:0] rwords [PORTS];

    gpio_addr_dec #(.ADDR_W(ADDR_W), .BANK_STRIDE(BANK_STRIDE), .ALIAS_OFS(ALIAS_OFS),
                    .BANK_IDX(BANK_IDX), .PORTS(PORTS)) u_wdec (
        .addr(wr_addr), .hit(w_hit), .is_alias(w_alias), .grp(w_grp), .port(w_port));

    gpio_addr_dec #(.ADDR_W(ADDR_W), .BANK_STRIDE(BANK_STRIDE), .ALIAS_OFS(ALIAS_OFS),
                    .BANK_IDX(BANK_IDX), .PORTS(PORTS)) u_rdec (
        .addr(rd_addr), .hit(r_hit), .is_alias(r_alias), .grp(r_grp), .port(r_port));

    gpio_in_sync #(.W(NPINS)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pins_s));

    // Route the write strobe to the addressed port only.
    always_comb begin
        port_we = '0;
        if (wr_en && w_hit) port_we[w_port] = 1'b1;
    end

    for (genvar gp = 0; gp < PORTS; gp++) begin : g_port
        gpio_port_regs u_port (
            .clk      (clk),
            .rst_n    (rst_n),
            .we       (port_we[gp]),
            .w_alias  (w_alias),
            .w_grp    (w_grp),
            .wdata    (wr_data),
            .pins_sync(pins_s[gp*P +: P]),
            .r_alias  (r_alias),
            .r_grp    (r_grp),
            .rword    (rwords[gp]),
            .pad_out  (pin_out[gp*P +: P]),
            .pad_oe   (pin_oe[gp*P +: P]),
            .ien      (irq_en[gp*P +: P]),
            .itype    (irq_type[gp*TYPE_W +: TYPE_W])
        );
    end

    // Return the addressed port's word, zero outside the bank.
    always_comb begin
        rd_data = r_hit ? rwords[r_port] : '0;
    end

    p_single_port_we_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(port_we))
        else $error("more than one port strobed");

    p_out_of_bank_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && w_hit) |=> ($stable(pin_oe) && $stable(pin_out)
                               && $stable(irq_en) && $stable(irq_type)))
        else $error("state changed on a write outside this bank");
endmodule

// File: tb/tb_gpio_bank_regs.sv
module tb_gpio_bank_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [11:0] wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [11:0] rd_addr = '0;
    logic [31:0] pin_in = '0;
    logic [31:0] rd_data, rd_data_b;
    logic [31:0] pin_out, pin_oe, irq_en, pin_out_b, pin_oe_b, irq_en_b;
    logic [95:0] irq_type, irq_type_b;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    gpio_bank_regs dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .pin_in(pin_in), .pin_out(pin_out),
        .pin_oe(pin_oe), .irq_en(irq_en), .irq_type(irq_type));

    // Second geometry: stride 0x100, alias 0x80, bank 1 (base 0x100).
    gpio_bank_regs #(.BANK_STRIDE('h100), .ALIAS_OFS('h80), .BANK_IDX(1)) dut_b (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data_b), .pin_in(pin_in), .pin_out(pin_out_b),
        .pin_oe(pin_oe_b), .irq_en(irq_en_b), .irq_type(irq_type_b));

    task automatic check(input string req, input logic [95:0] act, input logic [95:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
        rd_addr = a;
        #1;
        check(req, 96'(rd_data), 96'(exp));
    endtask

    task automatic rd_chk_b(input string req, input logic [11:0] a, input logic [31:0] exp);
        rd_addr = a;
        #1;
        check(req, 96'(rd_data_b), 96'(exp));
    endtask

    task automatic t_reset();
        for (int p = 0; p < 4; p++) begin
            rd_chk("R1 mode", 12'(p*4), 0);
            rd_chk("R1 oe", 12'('h10 + p*4), 0);
            rd_chk("R1 out", 12'('h20 + p*4), 0);
            rd_chk("R1 type", 12'('h60 + p*4), 0);
        end
        check("R1 pads", {pin_oe, pin_out, irq_en}, 0);
        check("R1 type vec", irq_type, 0);
        rd_chk_b("R1 geometry b", 12'h120, 0);
    endtask

    task automatic t_direct();
        wr(12'h004, 32'hFFFF_FFA5);
        rd_chk("R2 mode port1 low byte only", 12'h004, 32'h0000_00A5);
        rd_chk("R7 port0 untouched", 12'h000, 0);
        rd_chk("R7 port2 untouched", 12'h008, 0);
        wr(12'h068, 32'hFFAB_CDEF);
        rd_chk("R2 type port2", 12'h068, 32'h00AB_CDEF);
        check("R2 type vector", 96'(irq_type[48 +: 24]), 96'(24'hABCDEF));
        wr(12'h05C, 32'h0000_0081);
        check("R2 irq enable port3", 96'(irq_en[31:24]), 96'(8'h81));
    endtask

    task automatic t_alias();
        wr(12'h804, 32'h0000_0F0A);
        rd_chk("R3 masked mode", 12'h004, 32'h0000_00AA);
        wr(12'h868, 32'h0000_FF00);
        rd_chk("R3 masked type keeps upper", 12'h068, 32'h00AB_CD00);
        wr(12'h85C, 32'h0000_0000);
        rd_chk("R3 empty mask no change", 12'h05C, 32'h0000_0081);
    endtask

    task automatic t_ignore();
        wr(12'h030, 32'h0000_00FF);
        wr(12'h830, 32'h0000_FFFF);
        wr(12'h044, 32'h0000_FFFF);
        wr(12'h074, 32'h0000_FFFF);
        rd_chk("R4 input reg after writes", 12'h030, 0);
        rd_chk("R4 alias input reads zero", 12'h830, 0);
        rd_chk("R4 status reads zero", 12'h044, 0);
        rd_chk("R4 clear reads zero", 12'h074, 0);
        rd_chk("R4 mode port1 intact", 12'h004, 32'h0000_00AA);
        rd_chk("R4 oe port1 intact", 12'h014, 0);
    endtask

    task automatic t_pads();
        wr(12'h000, 32'h0000_000F);
        wr(12'h010, 32'h0000_0033);
        wr(12'h020, 32'h0000_00FF);
        check("R5 oe needs mode and oe", 96'(pin_oe[7:0]), 96'(8'h03));
        check("R5 out while driven", 96'(pin_out[7:0]), 96'(8'h03));
        wr(12'h820, 32'h0000_0200);
        check("R5 out after masked clear", 96'(pin_out[7:0]), 96'(8'h01));
        check("R5 oe unchanged", 96'(pin_oe[7:0]), 96'(8'h03));
    endtask

    task automatic t_sync();
        @(negedge clk);
        pin_in = 32'h1234_5678;
        @(negedge clk);
        rd_chk("R6 not visible after one edge", 12'h030, 0);
        @(negedge clk);
        rd_chk("R6 visible after two edges", 12'h030, 32'h0000_0078);
        rd_chk("R6 port3 input", 12'h03C, 32'h0000_0012);
    endtask

    task automatic t_bank();
        wr(12'h104, 32'h0000_005A);
        rd_chk_b("R9 direct in bank1", 12'h104, 32'h0000_005A);
        rd_chk("R8 other bank ignored", 12'h004, 32'h0000_00AA);
        rd_chk("R8 outside window reads zero", 12'h104, 0);
        wr(12'h184, 32'h0000_F000);
        rd_chk_b("R9 alias at base+0x80", 12'h104, 32'h0000_000A);
        rd_chk_b("R8 bank0 address reads zero in b", 12'h004, 0);
        wr(12'h002, 32'h0000_00FF);
        rd_chk("R8 unaligned write ignored", 12'h000, 32'h0000_000F);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                rst_n = 1'b1;
                t_reset();
                t_direct();
                t_alias();
                t_ignore();
                t_pads();
                t_sync();
                t_bank();
            end
            begin
                repeat (5000) @(posedge clk);
                total++;
                bad++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        disable fork;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule